// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

An 8-bit up-counter advances on ticks from a free-running prescaler. A source bit and a 3-bit select code choose the prescaler ratio. A mode bit sets what the block does when the counter wraps from all ones to zero. In watchdog mode, the wrap can request a system reset. This happens only when a separate reset-enable bit is set, and the request is a pulse of fixed width. In interval mode, the wrap sets a sticky flag, and that flag can drive an interrupt line.

Software reaches the block through a small register bus with a 2-bit address, separate read and write strobes, and combinational read data. There are three registers:

- **Control/status (address 0):** bit 7 flag, bit 6 watchdog mode, bit 5 run, bit 4 alternate source, bit 3 interrupt enable, bits 2:0 select code.
- **Counter (address 1).**
- **Reset-enable (address 2):** bit 0.

Clearing the flag needs a handshake. Software must first read the control register while the flag is 1, and then write 0 to bit 7. If a wrap happens in the same cycle as that read or write, the wrap wins.

Top module: `wdt_dual`

## Requirements
- R1: After reset, all three registers read as zero, and `irq` and `rst_req` are low.
- R2: While run (control bit 5) is 0, the counter keeps its value. From the edge that sets run, the counter advances by one every divide-ratio cycles. The first increment comes one full ratio after the start.
- R3: With the alternate source bit (control bit 4) at 0, select codes 0..7 divide by 2, 64, 128, 512, 2048, 8192, 32768 and 131072. With the bit at 1, code c divides by 2^(c+1).
- R4: A counter wrap from 0xFF to 0x00 sets the flag (control bit 7). Writing 1 to bit 7 never sets it.
- R5: In interval mode (control bit 6 = 0), `irq` is high exactly when the flag and interrupt enable (control bit 3) are both 1.
- R6: In watchdog mode with reset-enable (address 2, bit 0) set, a wrap raises `rst_req` for RST_PULSE cycles, starting the cycle after the wrap edge. `irq` stays low in watchdog mode.
- R7: With reset-enable at 0, a wrap produces no `rst_req`.
- R8: A write of 0 to bit 7 clears the flag only when a read of the control register saw the flag as 1 after the last clear attempt. Otherwise the write leaves the flag set.
- R9: When a wrap coincides with a clear write, the flag stays 1 and the read arming is cancelled. A read that coincides with a wrap does not arm a clear.
- R10: Writes to the counter register are ignored while run is 1.
- R11: While run is 1, writes leave the mode, source and select fields unchanged. Run and interrupt enable stay writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (arms flag clear) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| irq | output | 1 | Interval interrupt |
| rst_req | output | 1 | Watchdog reset request pulse |

## Verification
Properties checked on every cycle:

- The counter holds when stopped.
- The flag rises only from a wrap and falls only after a read armed the clear.
- Arming follows a read of a set flag.
- A reset pulse starts only from watchdog mode with reset-enable set.
- `irq` is silent in watchdog mode.
- The configuration fields do not move while running.

The directed scenarios establish what a property cannot:

- The exact count rates for several select codes.
- The pulse width and its start cycle.
- The two race cases that are timed to land on the wrap edge.

// File: rtl/wdt_dual.sv
module wdt_dual #(
  parameter int CNT_W     = 8,
  parameter int PRE_W     = 17,
  parameter int RST_PULSE = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       rst_req
);
  localparam int RW = $clog2(RST_PULSE + 1);

  logic             flag, armed, wdog, run, alt, irq_en, rst_en;
  logic [2:0]       sel;
  logic [CNT_W-1:0] cnt;
  logic [PRE_W-1:0] pre, mask;
  logic [RW-1:0]    rst_cnt;
  logic [4:0]       rate_lg;
  logic             tick, wrap;

  wire wr_ctrl = bus_wr && bus_addr == 2'd0;
  wire wr_cnt  = bus_wr && bus_addr == 2'd1;
  wire wr_ena  = bus_wr && bus_addr == 2'd2;
  wire rd_ctrl = bus_rd && bus_addr == 2'd0;
  wire clr_try = wr_ctrl && !bus_wdata[7];

  always_comb begin
    if (alt) rate_lg = 5'(sel) + 5'd1;
    else begin
      case (sel)
        3'd0:    rate_lg = 5'd1;
        3'd1:    rate_lg = 5'd6;
        3'd2:    rate_lg = 5'd7;
        3'd3:    rate_lg = 5'd9;
        3'd4:    rate_lg = 5'd11;
        3'd5:    rate_lg = 5'd13;
        3'd6:    rate_lg = 5'd15;
        default: rate_lg = 5'd17;
      endcase
    end
  end

  assign mask = (PRE_W'(1) << rate_lg) - PRE_W'(1);
  assign tick = run && ((pre & mask) == mask);
  assign wrap = tick && (cnt == '1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   pre <= '0;
    else if (!run) pre <= '0;
    else          pre <= pre + PRE_W'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              cnt <= '0;
    else if (wr_cnt && !run) cnt <= bus_wdata[CNT_W-1:0];
    else if (tick)           cnt <= cnt + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; wdog <= 1'b0; alt <= 1'b0; sel <= '0;
      irq_en <= 1'b0; rst_en <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        run    <= bus_wdata[5];
        irq_en <= bus_wdata[3];
        if (!run) begin
          wdog <= bus_wdata[6];
          alt  <= bus_wdata[4];
          sel  <= bus_wdata[2:0];
        end
      end
      if (wr_ena) rst_en <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else if (wrap) begin
      flag  <= 1'b1;
      armed <= 1'b0;
    end else if (clr_try) begin
      if (armed) flag <= 1'b0;
      armed <= 1'b0;
    end else if (rd_ctrl && flag) begin
      armed <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     rst_cnt <= '0;
    else if (wrap && wdog && rst_en) rst_cnt <= RW'(RST_PULSE);
    else if (rst_cnt != '0)         rst_cnt <= rst_cnt - RW'(1);

  assign rst_req = rst_cnt != '0;
  assign irq     = flag && irq_en && !wdog;

  always_comb begin
    case (bus_addr)
      2'd0:    bus_rdata = {flag, wdog, run, alt, irq_en, sel};
      2'd1:    bus_rdata = 8'(cnt);
      2'd2:    bus_rdata = {7'd0, rst_en};
      default: bus_rdata = 8'd0;
    endcase
  end
endmodule

module wdt_dual_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             wdog,
  input logic             rst_en,
  input logic             flag,
  input logic             armed,
  input logic [CNT_W-1:0] cnt,
  input logic [4:0]       cfg,
  input logic             irq,
  input logic             rst_req,
  input logic             bus_wr,
  input logic             bus_rd,
  input logic [1:0]       bus_addr
);
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !(bus_wr && bus_addr == 2'd1)) |=> $stable(cnt)); // R2
  AST_FLAG_FROM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(cnt) == '1 && cnt == '0 && $past(run))); // R4
  AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(armed)); // R8
  AST_ARM_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed) |-> ($past(flag) && $past(bus_rd) && $past(bus_addr) == 2'd0)); // R9
  AST_NO_IRQ_WDOG: assert property (@(posedge clk) disable iff (!rst_n)
    wdog |-> !irq); // R6
  AST_RESET_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> ($past(wdog) && $past(rst_en))); // R7
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(run) |-> $stable(cfg)); // R11
endmodule

bind wdt_dual wdt_dual_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .run(run), .wdog(wdog), .rst_en(rst_en),
  .flag(flag), .armed(armed), .cnt(cnt), .cfg({wdog, alt, sel}),
  .irq(irq), .rst_req(rst_req), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr)
);

// File: tb/wdt_dual_tb_top.sv
`timescale 1ns/1ps
module wdt_dual_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, rst_req;
  int checks = 0, fails = 0;

  wdt_dual dut_i (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_req(rst_req));

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 cnt", v, 0);
    rd(2'd2, v); chk("R1 ena", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rst_req", rst_req, 0);
  endtask

  task automatic t_hold_and_count;
    logic [7:0] v, a;
    wr(2'd1, 8'h37);
    repeat (10) @(negedge clk);
    rd(2'd1, v); chk("R2 stopped hold", v, 8'h37);
    wr(2'd0, 8'h30);
    repeat (20) @(negedge clk);
    rd(2'd1, v); chk("R2 div2 count", v, 8'h41);
    wr(2'd0, 8'h00);
    rd(2'd1, a); chk("R2 value at stop", a, 8'h42);
    repeat (10) @(negedge clk);
    rd(2'd1, v); chk("R2 hold after stop", v, a);
  endtask

  task automatic t_rates;
    logic [7:0] v;
    wr(2'd1, 8'h00); wr(2'd0, 8'h21);
    repeat (200) @(negedge clk);
    rd(2'd1, v); chk("R3 default code1 div64", v, 3);
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00); wr(2'd0, 8'h32);
    repeat (40) @(negedge clk);
    rd(2'd1, v); chk("R3 alt code2 div8", v, 5);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_freeze;
    logic [7:0] v;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd0, 8'h30);
    wr(2'd0, 8'h67);
    wr(2'd1, 8'h99);
    rd(2'd1, v); chk("R10 cnt write ignored while running", v, 1);
    rd(2'd0, v); chk("R11 cfg frozen while running", v, 8'h30);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_interval;
    logic [7:0] v;
    wr(2'd1, 8'hFE); wr(2'd0, 8'h38);
    repeat (3) @(negedge clk);
    chk("R5 irq before wrap", irq, 0);
    @(negedge clk);
    chk("R5 irq after wrap", irq, 1);
    wr(2'd0, 8'h38);
    rd(2'd0, v); chk("R8 unarmed clear ignored", v, 8'hB8);
    chk("R4 flag set by wrap", v[7], 1);
    wr(2'd0, 8'hB0);
    chk("R5 irq masked by enable", irq, 0);
    wr(2'd0, 8'h30);
    rd(2'd0, v); chk("R8 armed clear works", v, 8'h30);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_watchdog(input logic ena, input string tag);
    logic [7:0] v;
    int hi = 0, first = 0, irq_hi = 0;
    wr(2'd2, {7'd0, ena}); wr(2'd1, 8'hFE); wr(2'd0, 8'h78);
    for (int i = 1; i <= 12; i++) begin
      @(negedge clk);
      if (rst_req) begin hi++; if (first == 0) first = i; end
      if (irq) irq_hi++;
    end
    chk({tag, " pulse width"}, hi, ena ? 4 : 0);
    chk({tag, " pulse start"}, first, ena ? 4 : 0);
    chk("R6 irq silent in watchdog mode", irq_hi, 0);
    rd(2'd0, v); chk({tag, " flag in watchdog mode"}, v, 8'hF8);
    wr(2'd0, 8'h00);
    rd(2'd0, v); chk("R11 stop write keeps frozen fields", v, 8'h50);
    wr(2'd0, 8'h00);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_race;
    logic [7:0] v;
    wr(2'd1, 8'hFE); wr(2'd0, 8'h30);
    repeat (6) @(negedge clk);
    wr(2'd0, 8'h10);
    wr(2'd1, 8'hFE); wr(2'd0, 8'hB0);
    repeat (3) @(negedge clk);
    rd(2'd0, v); chk("R9 read on wrap sees flag", v, 8'hB0);
    wr(2'd0, 8'h30);
    rd(2'd0, v); chk("R9 read on wrap does not arm", v, 8'hB0);
    wr(2'd0, 8'h90);
    wr(2'd1, 8'hFE); wr(2'd0, 8'hB0);
    repeat (3) @(negedge clk);
    wr(2'd0, 8'h30);
    wr(2'd0, 8'h30);
    rd(2'd0, v); chk("R9 set wins and cancels arming", v, 8'hB0);
    wr(2'd0, 8'h30);
    rd(2'd0, v); chk("R9 later armed clear", v, 8'h30);
    wr(2'd0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_hold_and_count;
    t_rates;
    t_freeze;
    t_interval;
    t_watchdog(1'b1, "R6");
    t_watchdog(1'b0, "R7");
    t_race;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule